// File: doc/BRIEF.md
# E1 Frame Alignment Searcher

This block watches a received E1 serial stream, one bit per cycle of its recovered clock, and locates the 256-bit frame boundary. It runs a sliding hunt for the 7-bit alignment word, 0011011. Each hit becomes a candidate. A candidate is accepted only after a three-frame confirmation. After acceptance the block loads its timeslot, bit and frame counters to the new phase and emits a frame sync pulse on every frame wrap. A loss-of-sync flag shows whether the outgoing timing can be trusted.

When the multiframe option is on, acceptance does not clear the loss flag. Instead the block sends a start pulse to an external multiframe searcher and waits for its answer. A "found" answer loads the frame counter and clears the flag. A timeout answer sends the block back to frame hunting. Once locked, the alignment word is checked in every alignment-carrying frame. A run of misses starts a fresh search, but only when automatic resync is enabled.

Top module: `e1fa_aligner`

## Requirements
- R1: While reset is held and just after it, los is 1, mf_start is 0, frame_sync is 0, and ts_num, bit_num and frame_num are 0.
- R2: Bits of a timeslot arrive bit 1 first. The alignment word 0011011 occupies bits 2 to 8 of timeslot 0, and bit 2 arrives first. Before the first sampled bit, the history window reads as zeros.
- R3: A candidate found in frame N is accepted only if the word is absent at the same phase in frame N+1 and present again in frame N+2. Acceptance happens on the edge that samples bit 8 of timeslot 0 of frame N+2.
- R4: A candidate is rejected if the bit at the word's bit-2 position in frame N+1 is 0.
- R5: After a rejection, hunting resumes at the bit just after the rejected candidate's last bit, in the following frame period.
- R6: After acceptance the counters present ts_num=1, bit_num=0, frame_num=0 and fas_frame=1. They then advance by one bit per cycle. frame_sync is high exactly in the cycle after a wrap to ts_num=0, bit_num=0, and fas_frame toggles on each wrap.
- R7: With mf_search_en=0, los falls on the acceptance edge. mf_start stays 0.
- R8: With mf_search_en=1, mf_start is a one-cycle pulse after acceptance and los stays 1. A later mf_found clears los on that edge and sets frame_num to all ones, and the bit counters are left untouched.
- R9: An mf_timeout while waiting for the multiframe result keeps los at 1 and restarts the frame hunt at the next bit.
- R10: While locked with auto_resync_en=1, three consecutive misses of the word at bit 8 of timeslot 0 in alignment frames raise los and restart the hunt. A correct word clears the miss run.
- R11: With auto_resync_en=0, misses never raise los.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data |
| auto_resync_en | input | 1 | Allows resync after repeated alignment-word misses |
| mf_search_en | input | 1 | Hand off to the multiframe searcher after frame acceptance |
| mf_found | input | 1 | Multiframe searcher reports alignment |
| mf_timeout | input | 1 | Multiframe searcher gives up |
| ts_num | output | 5 | Timeslot of the bit now presented |
| bit_num | output | 3 | Bit within the timeslot (0 = bit 1) |
| frame_num | output | 4 | Frame counter |
| fas_frame | output | 1 | Current frame carries the alignment word |
| frame_sync | output | 1 | One-cycle pulse at each frame start |
| los | output | 1 | Loss of synchronization |
| mf_start | output | 1 | Pulse that starts the multiframe search |

## Verification
The bench sweeps the stream start phase, including the phases where a partly received word combined with the zero history still forms a real match. A design that mishandled the history would lock one frame late or on a false phase. Two decoy streams plant an imitation word ahead of the real one. One decoy is missing from frame N+2, and the other has a 0 at the bit-2 position of frame N+1. A design that skipped either test would lock onto the decoy at the wrong timeslot, and one that resumed at the wrong phase would lock one or more frames late. The multiframe handshake, the timeout restart, and the miss-run rule (including a good word breaking the run) are checked to the exact edge on which los changes.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  typedef enum logic [1:0] {SR_IDLE, SR_HUNT, SR_SKIP, SR_VERIFY} srch_st_t;
  typedef enum logic [1:0] {LK_SEARCH, LK_MFWAIT, LK_LOCKED} lock_st_t;
endpackage

// File: rtl/e1fa_window.sv
module e1fa_window #(
  parameter int PAT_W = 7,
  parameter logic [PAT_W-1:0] PATTERN = 7'b0011011
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  output logic hit
);
  logic [PAT_W-2:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[PAT_W-3:0], rx_bit};
  end

  // oldest bit in the MSB, the bit being sampled in the LSB
  assign hit = ({hist, rx_bit} == PATTERN);
endmodule

// File: rtl/e1fa_search.sv
module e1fa_search
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int PAT_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic rx_bit,
  input  logic hit,
  output logic found
);
  localparam int PW = $clog2(FRAME_BITS);
  localparam int CW = $clog2(2*FRAME_BITS + 1);
  localparam logic [CW-1:0] NFAS_AT = CW'(FRAME_BITS - (PAT_W - 1));
  localparam logic [CW-1:0] GAP_AT  = CW'(FRAME_BITS);
  localparam logic [CW-1:0] FINAL_AT = CW'(2*FRAME_BITS);

  srch_st_t st;
  logic [CW-1:0] cnt;
  logic reject;

  assign reject = (cnt == NFAS_AT && !rx_bit) ||
                  (cnt == GAP_AT && hit) ||
                  (cnt == FINAL_AT && !hit);
  assign found = (st == SR_VERIFY) && (cnt == FINAL_AT) && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SR_HUNT;
      cnt <= '0;
    end else if (restart) begin
      st  <= SR_HUNT;
      cnt <= '0;
    end else begin
      case (st)
        SR_HUNT: if (hit) begin
          st  <= SR_VERIFY;
          cnt <= CW'(1);
        end
        SR_VERIFY: begin
          cnt <= cnt + 1'b1;
          if (found) st <= SR_IDLE;
          else if (reject) st <= (cnt[PW-1:0] == '0) ? SR_HUNT : SR_SKIP;
        end
        SR_SKIP: begin
          cnt <= cnt + 1'b1;
          if (cnt[PW-1:0] == '0) st <= SR_HUNT;
        end
        default: ;
      endcase
    end
  end

  // R3
  verify_window_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SR_VERIFY) |-> (cnt != '0 && cnt <= FINAL_AT));
  // R4
  nfas_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SR_VERIFY && cnt == NFAS_AT && !rx_bit && !restart) |=> (st == SR_SKIP));
  // R5
  resume_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SR_SKIP && cnt[PW-1:0] == '0 && !restart) |=> (st == SR_HUNT));
endmodule

// File: rtl/e1fa_timing.sv
module e1fa_timing #(
  parameter int FRAME_BITS = 256,
  parameter int FRM_W = 4,
  parameter int REALIGN_POS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic realign,
  input  logic mf_align,
  output logic [$clog2(FRAME_BITS)-1:0] pos,
  output logic [FRM_W-1:0] frm,
  output logic fas_ph,
  output logic fsync
);
  localparam int PW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      frm    <= '0;
      fas_ph <= 1'b0;
      fsync  <= 1'b0;
    end else if (realign) begin
      pos    <= PW'(REALIGN_POS);
      frm    <= '0;
      fas_ph <= 1'b1;
      fsync  <= 1'b0;
    end else begin
      pos   <= pos + 1'b1;
      fsync <= (pos == LAST);
      if (pos == LAST) fas_ph <= ~fas_ph;
      if (mf_align)         frm <= '1;
      else if (pos == LAST) frm <= frm + 1'b1;
    end
  end

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !realign |=> (pos == PW'($past(pos) + 1'b1)));
  // R6
  fsync_pos_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |-> (pos == '0));
endmodule

// File: rtl/e1fa_aligner.sv
module e1fa_aligner
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int FRM_W = 4,
  parameter int ERR_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic auto_resync_en,
  input  logic mf_search_en,
  input  logic mf_found,
  input  logic mf_timeout,
  output logic [$clog2(FRAME_BITS)-4:0] ts_num,
  output logic [2:0] bit_num,
  output logic [FRM_W-1:0] frame_num,
  output logic fas_frame,
  output logic frame_sync,
  output logic los,
  output logic mf_start
);
  localparam int PW = $clog2(FRAME_BITS);
  localparam int PAT_W = 7;
  localparam logic [PAT_W-1:0] FAS_WORD = 7'b0011011;
  localparam int EW = $clog2(ERR_LIMIT + 1);
  localparam logic [PW-1:0] CHECK_POS = PW'(PAT_W);
  localparam logic [EW-1:0] LAST_MISS = EW'(ERR_LIMIT - 1);

  lock_st_t lk;
  logic hit, found, restart, mf_align, fas_ph, check_now, resync_go;
  logic [PW-1:0] pos;
  logic [EW-1:0] miss_run;

  e1fa_window #(.PAT_W(PAT_W), .PATTERN(FAS_WORD)) win_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .hit(hit));

  e1fa_search #(.FRAME_BITS(FRAME_BITS), .PAT_W(PAT_W)) srch_i (
    .clk(clk), .rst(rst), .restart(restart), .rx_bit(rx_bit),
    .hit(hit), .found(found));

  e1fa_timing #(.FRAME_BITS(FRAME_BITS), .FRM_W(FRM_W), .REALIGN_POS(PAT_W + 1)) tim_i (
    .clk(clk), .rst(rst), .realign(found), .mf_align(mf_align),
    .pos(pos), .frm(frame_num), .fas_ph(fas_ph), .fsync(frame_sync));

  assign ts_num    = pos[PW-1:3];
  assign bit_num   = pos[2:0];
  assign fas_frame = fas_ph;

  assign mf_align  = (lk == LK_MFWAIT) && mf_found;
  assign check_now = (lk == LK_LOCKED) && (pos == CHECK_POS) && fas_ph;
  assign resync_go = check_now && !hit && auto_resync_en && (miss_run == LAST_MISS);
  assign restart   = ((lk == LK_MFWAIT) && !mf_found && mf_timeout) || resync_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk       <= LK_SEARCH;
      los      <= 1'b1;
      mf_start <= 1'b0;
      miss_run <= '0;
    end else begin
      mf_start <= 1'b0;
      case (lk)
        LK_SEARCH: if (found) begin
          miss_run <= '0;
          if (mf_search_en) begin
            lk       <= LK_MFWAIT;
            mf_start <= 1'b1;
          end else begin
            lk  <= LK_LOCKED;
            los <= 1'b0;
          end
        end
        LK_MFWAIT: begin
          if (mf_found) begin
            lk  <= LK_LOCKED;
            los <= 1'b0;
          end else if (mf_timeout) begin
            lk <= LK_SEARCH;
          end
        end
        LK_LOCKED: if (check_now) begin
          if (hit) miss_run <= '0;
          else if (resync_go) begin
            lk       <= LK_SEARCH;
            los      <= 1'b1;
            miss_run <= '0;
          end else if (miss_run != LAST_MISS) miss_run <= miss_run + 1'b1;
        end
        default: lk <= LK_SEARCH;
      endcase
    end
  end

  // R7
  search_los_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> los);
  // R8
  mf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mf_start |=> !mf_start);
  // R8
  mf_los_chk: assert property (@(posedge clk) disable iff (rst)
    mf_start |-> los);
  // R10
  resync_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> ($past(lk) == LK_LOCKED && $past(auto_resync_en)));
  // R11
  no_auto_chk: assert property (@(posedge clk) disable iff (rst)
    (lk == LK_LOCKED && !auto_resync_en) |=> !los);
endmodule

// File: tb/e1fa_aligner_tb.sv
`timescale 1ns/1ps
module e1fa_aligner_tb_top;
  localparam logic [6:0] FASP = 7'b0011011;
  localparam int FB = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit = 1'b0;
  logic auto_en = 1'b1, mf_en = 1'b0, mf_found = 1'b0, mf_to = 1'b0;
  logic [4:0] ts_num;
  logic [2:0] bit_num;
  logic [3:0] frame_num;
  logic fas_frame, frame_sync, los, mf_start;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  e1fa_aligner dut_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .auto_resync_en(auto_en),
    .mf_search_en(mf_en), .mf_found(mf_found), .mf_timeout(mf_to),
    .ts_num(ts_num), .bit_num(bit_num), .frame_num(frame_num),
    .fas_frame(fas_frame), .frame_sync(frame_sync), .los(los), .mf_start(mf_start));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode 0 clean, 1 decoy in frame 1, 2 decoys in frames 1/3 with bad bit-2, 3 lost words
  function automatic logic gen_bit(input int gi, input int md);
    int f, p;
    f = gi / FB;
    p = gi % FB;
    if (p == 0) return 1'b1;
    if (p < 8) begin
      if (f % 2 == 1) return 1'b1;
      if (md == 3 && f >= 4 && f != 8) return 1'b1;
      return FASP[7-p];
    end
    if (md == 2 && f == 2 && p == 41) return 1'b0;
    if (p >= 41 && p <= 47 && ((md == 1 && f == 1) || (md == 2 && (f == 1 || f == 3))))
      return FASP[47-p];
    return 1'b1;
  endfunction

  // R2: zero history before the first bit, word must fill the window
  function automatic int exp_accept(input int g0);
    for (int g = g0; g < g0 + 2000; g++) begin
      if (g % 512 == 7) begin
        bit ok;
        ok = 1'b1;
        for (int k = 0; k < 7; k++) begin
          int gi;
          logic b;
          gi = g - 6 + k;
          b = (gi < g0) ? 1'b0 : gen_bit(gi, 0);
          if (b != FASP[6-k]) ok = 1'b0;
        end
        if (ok) return g + 512;
      end
    end
    return -1;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    rx_bit = 1'b0;
    mf_found = 1'b0;
    mf_to = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tick(input logic b);
    rx_bit = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  // feeds bits from g0 until los falls; returns the index that produced it
  task automatic run_to_lock(input int g0, input int md, input int lim, output int hitg);
    hitg = -1;
    for (int g = g0; g < g0 + lim && hitg < 0; g++) begin
      tick(gen_bit(g, md));
      if (los == 1'b0) hitg = g;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int got, exp, g0;
    // reset state
    do_reset();
    check(los == 1'b1 && mf_start == 1'b0 && frame_sync == 1'b0, "R1 flags", {los, mf_start, frame_sync}, 3'b100);
    check(ts_num == 0 && bit_num == 0 && frame_num == 0, "R1 counters", {ts_num, bit_num}, 0);

    // start-phase sweep, clean stream
    auto_en = 1'b1;
    mf_en = 1'b0;
    for (int k = 0; k < 18; k++) begin
      g0 = (k < 8) ? k : (k * 53) % 512;
      exp = exp_accept(g0);
      do_reset();
      run_to_lock(g0, 0, 1600, got);
      check(got == exp, "R3/R2/R7 lock edge", got, exp);
      check(ts_num == 1 && bit_num == 0 && frame_num == 0 && fas_frame == 1'b1 && mf_start == 1'b0,
            "R6 realign", {ts_num, bit_num}, 8);
      if (got >= 0) begin
        for (int n = 1; n <= 300; n++) begin
          int p, fr;
          tick(gen_bit(got + n, 0));
          p = (8 + n) % FB;
          fr = ((8 + n) / FB) % 16;
          check({ts_num, bit_num} == 8'(p) && frame_num == 4'(fr) && frame_sync == (p == 0) &&
                fas_frame == (fr % 2 == 0) && los == 1'b0, "R6 count", {ts_num, bit_num}, p);
        end
      end
    end

    // decoy missing from frame N+2
    do_reset();
    run_to_lock(256, 1, 2000, got);
    check(got == 1543, "R3/R5 decoy third frame", got, 1543);
    check(ts_num == 1 && bit_num == 0, "R3 decoy phase", {ts_num, bit_num}, 8);

    // decoy whose frame N+1 has bit 2 cleared
    do_reset();
    run_to_lock(256, 2, 2500, got);
    check(got == 2055, "R4/R5 decoy bit2", got, 2055);
    check(ts_num == 1 && bit_num == 0, "R4 decoy phase", {ts_num, bit_num}, 8);

    // multiframe handshake
    mf_en = 1'b1;
    do_reset();
    for (int g = 0; g <= 519; g++) tick(gen_bit(g, 0));
    check(mf_start == 1'b1 && los == 1'b1, "R8 start pulse", {mf_start, los}, 3);
    tick(gen_bit(520, 0));
    check(mf_start == 1'b0 && los == 1'b1, "R8 pulse ends", {mf_start, los}, 1);
    for (int g = 521; g <= 600; g++) tick(gen_bit(g, 0));
    check(los == 1'b1, "R8 los held", los, 1);
    mf_found = 1'b1;
    tick(gen_bit(601, 0));
    mf_found = 1'b0;
    check(los == 1'b0 && frame_num == 4'hF, "R8 found", frame_num, 15);
    check({ts_num, bit_num} == 8'd90, "R8 bits untouched", {ts_num, bit_num}, 90);
    for (int g = 602; g <= 767; g++) tick(gen_bit(g, 0));
    check(frame_num == 0 && frame_sync == 1'b1, "R8 wrap", frame_num, 0);

    // multiframe timeout
    do_reset();
    for (int g = 0; g <= 600; g++) begin
      mf_to = (g == 600);
      tick(gen_bit(g, 0));
    end
    mf_to = 1'b0;
    check(los == 1'b1, "R9 los after timeout", los, 1);
    got = -1;
    for (int g = 601; g <= 1600 && got < 0; g++) begin
      tick(gen_bit(g, 0));
      if (mf_start) got = g;
    end
    check(got == 1543, "R9 new search", got, 1543);

    // auto resync with a good word breaking the miss run
    mf_en = 1'b0;
    auto_en = 1'b1;
    do_reset();
    got = -1;
    for (int g = 0; g <= 4000; g++) begin
      tick(gen_bit(g, 3));
      if (g > 519 && los == 1'b1 && got < 0) got = g;
    end
    check(got == 3591, "R10 resync edge", got, 3591);
    check(los == 1'b1, "R10 stays searching", los, 1);

    // auto resync disabled
    auto_en = 1'b0;
    do_reset();
    got = -1;
    for (int g = 0; g <= 4200; g++) begin
      tick(gen_bit(g, 3));
      if (g > 519 && los == 1'b1 && got < 0) got = g;
    end
    check(got == -1, "R11 no resync", got, -1);
    check(los == 1'b0, "R11 los low", los, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule